// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a register-driven master for the two-wire PHY management bus. Software places a whole management transaction in one 32-bit frame word. That word holds the start code, the opcode, the PHY address, the register address, the turnaround pattern and 16 data bits. Writing the word starts the transfer. The controller then produces the management clock and shifts out a preamble of 32 ones, followed by the 32 frame bits, most significant bit first.

For a read, the controller lets go of the data line from the turnaround bits onward. It gathers the 16 bits the PHY returns and writes them into the low half of the frame word. The management clock rate comes from a divider field that software programs from the system clock frequency. When a transfer ends, a sticky event bit is set. Software clears it by writing a one to it.

The register map has four 32-bit words, chosen by a 2-bit address. Index 0 is the frame word. Index 1 is the event word, with the done flag in bit 0. Index 2 is the speed word, with the divider in bits 6:1. Index 3 is the status word, with the busy flag in bit 0.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The frame word layout is fixed:
  - bits 31:30 start code 01;
  - bits 29:28 opcode (10 is read, any other value is handled as a write);
  - bits 27:23 PHY address;
  - bits 22:18 register address;
  - bits 17:16 turnaround 10;
  - bits 15:0 data.

  A write to index 0, while the block is idle and the divider is nonzero, starts a transfer. On the data line the transfer is 32 ones, then frame bits 31 down to 0.
- R2: The management clock idles low. During a transfer it has a period of 2×divider system clocks, and its low half comes first. The data output changes only together with a falling clock edge, so it is stable at every rising edge.
- R3: The divider sits in bits 6:1 of index 2 and reads back in the same place. With a divider of 0, a frame write is ignored: no transfer starts, the clock stays low and the frame word is not changed.
- R4: For a read, the output enable is low from the first turnaround bit (serial position 46 of 0..63) to the end of the transfer. The PHY data is sampled as the clock rises, for serial positions 48..63, with the first bit received going to bit 15. When the transfer ends, the sampled value replaces frame bits 15:0, and bits 31:16 are kept.
- R5: For a write, the output enable is high for all 64 serial bits, and the frame word is not changed by the transfer.
- R6: Completion sets bit 0 of index 1. Writing 1 to that bit clears it, and writing 0 has no effect. If completion and a clearing write fall in the same cycle, the bit ends up set.
- R7: Bit 0 of index 3 reads 1 while a transfer is in progress. A frame write during that time is ignored and does not disturb the transfer.
- R8: After reset the clock is low, the output enable is low, and all four register words read 0.
- R9: bus_rdata is registered. It shows the word selected by bus_addr in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
Two functions can meet in one cycle: a transfer completing, which sets the event bit, and a software write of 1 that clears it. The bench starts a write transfer at a known edge and counts 128×divider clock edges from that edge. It places the clearing write exactly on the edge where the final falling clock ends the transfer, with the event bit previously clear. It then judges that the bit reads back as 1, because the set has priority. A second overlap, a frame write arriving while a transfer is busy, is judged by checking that the serial stream still matches the original frame and that the frame word is unchanged.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int ADDR_W  = 2;
  localparam int FRAME_W = 32;
  localparam int DATA_W  = 16;

  typedef enum logic [ADDR_W-1:0] {
    REG_FRAME  = 2'd0,
    REG_EVENT  = 2'd1,
    REG_SPEED  = 2'd2,
    REG_STATUS = 2'd3
  } reg_sel_e;

  localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             edge_hit;

  assign edge_hit = run && (cnt_q == div - 1'b1);
  assign rise_stb = edge_hit & ~mdc_q;
  assign fall_stb = edge_hit & mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (edge_hit) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter #(
  parameter int PRE_LEN = 32,
  parameter int FRAME_W = 32,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               rd_op,
  input  logic               rise_stb,
  input  logic               fall_stb,
  input  logic               mdio_i,
  output logic               busy,
  output logic               done,
  output logic               is_read,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic [DATA_W-1:0]  rd_data
);
  localparam int TOTAL  = PRE_LEN + FRAME_W;
  localparam int IDX_W  = $clog2(TOTAL);
  localparam int TA_POS = TOTAL - DATA_W - 2;
  localparam int DT_POS = TA_POS + 2;

  logic [TOTAL-1:0]  shreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  nxt_idx;
  logic              busy_q;
  logic              rd_q;
  logic              out_q;
  logic              oe_q;
  logic [DATA_W-1:0] cap_q;

  assign nxt_idx = idx_q + 1'b1;
  assign done    = busy_q && fall_stb && (idx_q == IDX_W'(TOTAL - 1));
  assign busy    = busy_q;
  assign is_read = rd_q;
  assign mdio_o  = out_q;
  assign mdio_oe = oe_q;
  assign rd_data = cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      out_q   <= 1'b1;
      oe_q    <= 1'b0;
    end else if (start) begin
      shreg_q <= {{PRE_LEN{1'b1}}, frame_in};
      idx_q   <= '0;
      busy_q  <= 1'b1;
      rd_q    <= rd_op;
      out_q   <= 1'b1;
      oe_q    <= 1'b1;
    end else if (done) begin
      busy_q  <= 1'b0;
      out_q   <= 1'b1;
      oe_q    <= 1'b0;
    end else if (busy_q && fall_stb) begin
      idx_q   <= nxt_idx;
      shreg_q <= shreg_q << 1;
      out_q   <= shreg_q[TOTAL-2];
      oe_q    <= !(rd_q && (nxt_idx >= IDX_W'(TA_POS)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
    end else if (busy_q && rise_stb && rd_q && (idx_q >= IDX_W'(DT_POS))) begin
      cap_q <= {cap_q[DATA_W-2:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter int DIV_LSB = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [FRAME_W-1:0] bus_wdata,
  input  logic               busy,
  input  logic               done,
  input  logic               is_read,
  input  logic [DATA_W-1:0]  rd_data,
  output logic [FRAME_W-1:0] bus_rdata,
  output logic [FRAME_W-1:0] frame_q,
  output logic [DIV_W-1:0]   div_run,
  output logic               event_q,
  output logic               start
);
  logic [DIV_W-1:0]   div_q;
  logic [DIV_W-1:0]   div_act_q;
  logic [FRAME_W-1:0] frame_r;
  logic               ev_r;
  logic [FRAME_W-1:0] rdata_q;
  logic               wr_frame, wr_event, wr_speed;

  assign wr_frame = bus_wr && (bus_addr == REG_FRAME);
  assign wr_event = bus_wr && (bus_addr == REG_EVENT);
  assign wr_speed = bus_wr && (bus_addr == REG_SPEED);
  assign start    = wr_frame && !busy && (div_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_r <= '0;
    end else if (start) begin
      frame_r <= bus_wdata;
    end else if (done && is_read) begin
      frame_r[DATA_W-1:0] <= rd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= '0;
      div_act_q <= '0;
    end else begin
      if (wr_speed) div_q <= bus_wdata[DIV_LSB +: DIV_W];
      if (start)    div_act_q <= div_q;
    end
  end

  // completion takes priority over a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_r <= 1'b0;
    end else if (done) begin
      ev_r <= 1'b1;
    end else if (wr_event && bus_wdata[0]) begin
      ev_r <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (reg_sel_e'(bus_addr))
        REG_FRAME:  rdata_q <= frame_r;
        REG_EVENT:  rdata_q <= FRAME_W'(ev_r);
        REG_SPEED:  rdata_q <= FRAME_W'({div_q, {DIV_LSB{1'b0}}});
        default:    rdata_q <= FRAME_W'(busy);
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign frame_q   = frame_r;
  assign div_run   = div_act_q;
  assign event_q   = ev_r;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic               busy_w, done_w, isrd_w, start_w, event_w;
  logic               rise_w, fall_w, rd_op_w;
  logic [DATA_W-1:0]  cap_w;
  logic [FRAME_W-1:0] frame_w;
  logic [DIV_W-1:0]   div_w;

  assign rd_op_w = (bus_wdata[FRAME_W-3 -: 2] == OP_READ);

  mdio_reg_file #(.DIV_W(DIV_W), .DIV_LSB(1)) regs_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy_w), .done(done_w), .is_read(isrd_w),
    .rd_data(cap_w), .bus_rdata(bus_rdata), .frame_q(frame_w),
    .div_run(div_w), .event_q(event_w), .start(start_w)
  );

  mdio_mdc_gen #(.DIV_W(DIV_W)) clkgen_i (
    .clk(clk), .rst(rst), .run(busy_w), .div(div_w),
    .mdc(mdc), .rise_stb(rise_w), .fall_stb(fall_w)
  );

  mdio_frame_shifter #(.PRE_LEN(PRE_LEN), .FRAME_W(FRAME_W), .DATA_W(DATA_W)) shift_i (
    .clk(clk), .rst(rst), .start(start_w), .frame_in(bus_wdata), .rd_op(rd_op_w),
    .rise_stb(rise_w), .fall_stb(fall_w), .mdio_i(mdio_i),
    .busy(busy_w), .done(done_w), .is_read(isrd_w),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(cap_w)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        mdc,
  input logic        mdio_oe,
  input logic        busy,
  input logic        done,
  input logic        event_bit,
  input logic [31:0] frame,
  input logic        bus_wr,
  input logic [1:0]  bus_addr
);
  p_mdc_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  p_line_released_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  p_event_on_done_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> event_bit);

  p_busy_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr && bus_addr == 2'd0 && !done) |=> (frame == $past(frame)));

  p_done_ends_busy_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk chk_i (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_oe(mdio_oe), .busy(busy_w),
  .done(done_w), .event_bit(event_w), .frame(frame_w),
  .bus_wr(bus_wr), .bus_addr(bus_addr)
);

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic [1:0]  exp_q[$];       // {oe, bit}
  int          rise_cnt = 0;
  int          exp_div  = 1;
  logic [15:0] phy_val  = '0;
  time         t_first  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_master dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected serial bits at each rising management clock
  always @(posedge mdc) begin
    logic [1:0] e;
    #1;
    rise_cnt++;
    if (rise_cnt == 1) t_first = $time;
    if (rise_cnt == 2)
      check(($time - t_first) == time'(2 * exp_div * CLK_PERIOD), "R2 period",
            32'($time - t_first), 32'(2 * exp_div * CLK_PERIOD));
    if (exp_q.size() == 0) begin
      check(1'b0, "R1 unexpected clock", 32'(rise_cnt), 32'd0);
    end else begin
      e = exp_q.pop_front();
      if (e[1] !== mdio_oe)
        check(1'b0, e[1] ? "R5 enable" : "R4 release", 32'(mdio_oe), 32'(e[1]));
      else if (e[1] && (e[0] !== mdio_o))
        check(1'b0, "R1 serial bit", 32'(mdio_o), 32'(e[0]));
    end
  end

  // PHY model: presents read data after each falling clock
  always @(negedge mdc) begin
    if (rise_cnt >= 48 && rise_cnt <= 63) mdio_i <= phy_val[63 - rise_cnt];
    else mdio_i <= 1'b1;
  end

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // driver: pushes the expected serial stream, then writes the frame word
  task automatic start_frame(input logic [31:0] f, input int div, input logic [15:0] pv);
    bit rd;
    rd = (f[29:28] == 2'b10);
    for (int i = 0; i < 32; i++) exp_q.push_back(2'b11);
    for (int j = 0; j < 32; j++) begin
      if (rd && (32 + j) >= 46) exp_q.push_back(2'b00);
      else exp_q.push_back({1'b1, f[31-j]});
    end
    rise_cnt = 0;
    exp_div  = div;
    phy_val  = pv;
    write_reg(2'd0, f);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 4000; k++) begin
      read_reg(2'd3, s);
      if (s[0] == 1'b0) break;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] f1, f2, f3, f4, f5;
    bit saw_mdc;
    f1 = {2'b01, 2'b01, 5'd5, 5'd1, 2'b10, 16'h1234};
    f2 = {2'b01, 2'b10, 5'd3, 5'd2, 2'b10, 16'h0000};
    f3 = {2'b01, 2'b01, 5'd31, 5'd17, 2'b10, 16'hC00F};
    f4 = {2'b01, 2'b01, 5'd1, 5'd1, 2'b10, 16'h5555};
    f5 = {2'b01, 2'b01, 5'd9, 5'd4, 2'b10, 16'h00FF};

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(mdc == 1'b0, "R8 mdc", 32'(mdc), 32'd0);
    check(mdio_oe == 1'b0, "R8 enable", 32'(mdio_oe), 32'd0);
    for (int a = 0; a < 4; a++) begin
      read_reg(2'(a), r);
      check(r == 32'd0, "R8 register", r, 32'd0);
    end

    // R3: divider readback at bits 6:1
    write_reg(2'd2, 32'd4);
    read_reg(2'd2, r);
    check(r == 32'h4, "R3 speed readback", r, 32'h4);

    // write transfer, divider 2
    start_frame(f1, 2, 16'h0);
    wait_idle();
    check(exp_q.size() == 0, "R1 all bits sent", 32'(exp_q.size()), 32'd0);
    read_reg(2'd0, r);
    check(r == f1, "R5 frame kept", r, f1);
    read_reg(2'd1, r);
    check(r == 32'd1, "R6 event set", r, 32'd1);
    write_reg(2'd1, 32'd0);
    read_reg(2'd1, r);
    check(r == 32'd1, "R6 write 0 no effect", r, 32'd1);
    write_reg(2'd1, 32'd1);
    read_reg(2'd1, r);
    check(r == 32'd0, "R6 write 1 clears", r, 32'd0);

    // read transfer, divider 1
    write_reg(2'd2, 32'd2);
    start_frame(f2, 1, 16'hA5C3);
    wait_idle();
    check(exp_q.size() == 0, "R1 all bits sent", 32'(exp_q.size()), 32'd0);
    read_reg(2'd0, r);
    check(r == {f2[31:16], 16'hA5C3}, "R4 read data", r, {f2[31:16], 16'hA5C3});
    write_reg(2'd1, 32'd1);

    // R7: write during busy
    write_reg(2'd2, 32'd6);
    start_frame(f3, 3, 16'h0);
    repeat (20) @(negedge clk);
    read_reg(2'd3, r);
    check(r == 32'd1, "R7 busy flag", r, 32'd1);
    write_reg(2'd0, f4);
    wait_idle();
    check(exp_q.size() == 0, "R7 stream intact", 32'(exp_q.size()), 32'd0);
    read_reg(2'd0, r);
    check(r == f3, "R7 frame unchanged", r, f3);
    write_reg(2'd1, 32'd1);

    // R3: divider 0 blocks
    write_reg(2'd2, 32'd0);
    write_reg(2'd0, f4);
    read_reg(2'd3, r);
    check(r == 32'd0, "R3 no start", r, 32'd0);
    saw_mdc = 1'b0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (mdc) saw_mdc = 1'b1;
    end
    check(!saw_mdc, "R3 clock stays low", 32'(saw_mdc), 32'd0);
    read_reg(2'd0, r);
    check(r == f3, "R3 frame unchanged", r, f3);

    // R6: clear collides with completion, set wins
    write_reg(2'd2, 32'd4);
    read_reg(2'd1, r);
    check(r == 32'd0, "R6 event clear before", r, 32'd0);
    start_frame(f5, 2, 16'h0);
    repeat (128 * 2 - 2) @(negedge clk);
    write_reg(2'd1, 32'd1);
    read_reg(2'd1, r);
    check(r == 32'd1, "R6 set wins", r, 32'd1);
    wait_idle();
    check(exp_q.size() == 0, "R1 all bits sent", 32'(exp_q.size()), 32'd0);

    // R9: registered read data
    @(negedge clk);
    bus_addr = 2'd1;
    @(negedge clk);
    bus_addr = 2'd2;
    #1;
    check(bus_rdata == 32'd1, "R9 old word held", bus_rdata, 32'd1);
    @(negedge clk);
    check(bus_rdata == 32'd4, "R9 new word", bus_rdata, 32'd4);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule